// File: doc/BRIEF.md
# Dual-line secondary interrupt controller

This block gathers a set of edge-triggered interrupt sources, eight by default, and presents them to two hosts that work independently. Each source input is synchronized and passed through one shared edge detector. The edge detector can be set to react to a rising transition, a falling transition, both, or neither. Every host has its own interrupt line, which is active low, and its own status and mask registers. One detected event therefore shows up in both status views, and each host acknowledges it on its own.

Each host has its own mode bit. In one mode, reading the status register clears the bits that the read returned. In the other mode, the host clears a bit by writing a 1 to it. If an event arrives while the same source is still pending on a line, the event is held in a buffer. It reappears in that line's status once the first event is cleared.

All access goes through a single synchronous register port. The port has separate read and write strobes and a 3-bit address. Read data is registered.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, both `irq_n` bits are 1, both status registers read 0x00, both mask registers read 0xFF, both edge-select bytes read 0x00 and the mode register reads 0x00.
- R2: Addresses: 0 = line 0 status, 1 = line 0 mask, 2 = line 1 status, 3 = line 1 mask, 4 = edge select for sources 0..3, 5 = edge select for sources 4..7, 6 = mode, 7 = unused (reads 0x00, writes ignored). Read data appears on `rdata` after the clock edge that samples `rd_en`.
- R3: For source i, the edge-select pair is in byte i/4, at bits (i mod 4)*2 and (i mod 4)*2+1. The upper bit enables rising detection and the lower bit enables falling detection. With both bits set, either edge is detected.
- R4: A source whose edge-select pair is 00 never sets a status bit on either line.
- R5: A detected edge sets the source's status bit in both lines' status registers, whatever the masks hold. The bit is set on the third rising clock edge after the input changes.
- R6: A mask bit of 1 keeps that source from driving that line. The two lines use separate masks.
- R7: `irq_n[l]` goes low one clock after (status AND NOT mask) of line l becomes nonzero. It returns high one clock after that value becomes zero.
- R8: Mode bit l (bit 0 for line 0, bit 1 for line 1) set to 1 selects clear-on-read for line l. A status read returns the bits and clears them, and writes to that status register have no effect.
- R9: With mode bit l at 0, writing 1 to a status bit clears it. Writing 0 leaves it unchanged, and reads do not clear it.
- R10: A second edge on a source whose status bit is still pending on a line is buffered. The bit reads as set again after the first clear, and reads as 0 after the next clear.
- R11: When a clear and a new edge on the same source fall in the same cycle, the status bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | N_SRC | Asynchronous interrupt source levels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_n | output | 2 | Active-low interrupt lines, one per host |

## Verification
The hardest case to reach from the ports is a clear that lands in the same cycle as a fresh detected edge. That cycle lies three clock edges behind the input change, because of the synchronizer and the sample register. The stimulus makes a bit pending first. It then toggles the source on a falling clock edge and counts two rising edges, so that the clear-on-read strobe lines up exactly with the edge-event cycle. The other line is left unread during this sequence, which drives its buffered-event path at the same moment. A sweep over every source and all four edge codes, in both directions, checks both lines against values computed from the edge-select rule.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int DW     = 8;
  localparam int NLINES = 2;

  typedef enum logic [2:0] {
    A_STAT0 = 3'd0,
    A_MASK0 = 3'd1,
    A_STAT1 = 3'd2,
    A_MASK1 = 3'd3,
    A_EDGE0 = 3'd4,
    A_EDGE1 = 3'd5,
    A_MODE  = 3'd6,
    A_SPARE = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/dirq_edge_det.sv
module dirq_edge_det #(
  parameter int N_SRC  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_in,
  input  logic [N_SRC-1:0] rise_en,
  input  logic [N_SRC-1:0] fall_en,
  output logic [N_SRC-1:0] event_o
);
  logic [N_SRC-1:0] sync_q [STAGES];
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) sync_q[k] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= src_in;
      for (int k = 1; k < STAGES; k++) sync_q[k] <= sync_q[k-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign cur     = sync_q[STAGES-1];
  assign event_o = (cur & ~prev_q & rise_en) | (~cur & prev_q & fall_en);
endmodule

// File: rtl/dirq_line.sv
module dirq_line #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] event_i,
  input  logic             mask_we,
  input  logic [N_SRC-1:0] mask_wdata,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] stat_o,
  output logic [N_SRC-1:0] mask_o,
  output logic             irq_n_o
);
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] held_q;
  logic [N_SRC-1:0] mask_q;
  logic             irq_n_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
        held_q[i] <= 1'b0;
      end else if (event_i[i]) begin
        pend_q[i] <= 1'b1;
        if (pend_q[i] && !clr_i[i]) held_q[i] <= 1'b1;
      end else if (clr_i[i] && pend_q[i]) begin
        pend_q[i] <= held_q[i];
        held_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '1;
      irq_n_q <= 1'b1;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      irq_n_q <= ~|(pend_q & ~mask_q);
    end
  end

  assign stat_o  = pend_q;
  assign mask_o  = mask_q;
  assign irq_n_o = irq_n_q;
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import dirq_pkg::*;
#(
  parameter int N_SRC       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_in,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [1:0]       irq_n
);
  localparam int EDGE_BYTES = (2 * N_SRC + 7) / 8;
  localparam int EW         = EDGE_BYTES * 8;
  localparam logic [EW-1:0] EDGE_VLD = {EW{1'b1}} >> (EW - 2 * N_SRC);

  logic [EW-1:0]    edge_q;
  logic [1:0]       mode_q;
  logic [N_SRC-1:0] rise_en, fall_en, event_w;
  logic [N_SRC-1:0] stat_w [NLINES];
  logic [N_SRC-1:0] mask_w [NLINES];
  logic [DW-1:0]    rd_mux;

  for (genvar i = 0; i < N_SRC; i++) begin : g_sel
    assign rise_en[i] = edge_q[2*i+1];
    assign fall_en[i] = edge_q[2*i];
  end

  dirq_edge_det #(.N_SRC(N_SRC), .STAGES(SYNC_STAGES)) det_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .rise_en(rise_en), .fall_en(fall_en), .event_o(event_w)
  );

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    localparam logic [2:0] STAT_A = 3'(2 * l);
    localparam logic [2:0] MASK_A = 3'(2 * l + 1);
    logic [N_SRC-1:0] clr_l;

    always_comb begin
      clr_l = '0;
      if (rd_en && addr == STAT_A && mode_q[l])
        clr_l = stat_w[l];
      else if (wr_en && addr == STAT_A && !mode_q[l])
        clr_l = wdata[N_SRC-1:0];
    end

    dirq_line #(.N_SRC(N_SRC)) line_i (
      .clk(clk), .rst_n(rst_n), .event_i(event_w),
      .mask_we(wr_en && addr == MASK_A), .mask_wdata(wdata[N_SRC-1:0]),
      .clr_i(clr_l), .stat_o(stat_w[l]), .mask_o(mask_w[l]),
      .irq_n_o(irq_n[l])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q <= '0;
      mode_q <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < EDGE_BYTES; b++)
        if (addr == 3'(int'(A_EDGE0) + b))
          edge_q[8*b +: 8] <= wdata & EDGE_VLD[8*b +: 8];
      if (addr == A_MODE) mode_q <= wdata[1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_STAT0: rd_mux[N_SRC-1:0] = stat_w[0];
      A_MASK0: rd_mux[N_SRC-1:0] = mask_w[0];
      A_STAT1: rd_mux[N_SRC-1:0] = stat_w[1];
      A_MASK1: rd_mux[N_SRC-1:0] = mask_w[1];
      A_MODE:  rd_mux[1:0]       = mode_q;
      default: begin
        for (int b = 0; b < EDGE_BYTES; b++)
          if (addr == 3'(int'(A_EDGE0) + b)) rd_mux = edge_q[8*b +: 8];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/dual_irq_ctrl_chk.sv
module dual_irq_ctrl_chk
  import dirq_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int EW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             wr_en,
  input logic [2:0]       addr,
  input logic [7:0]       rdata,
  input logic [1:0]       irq_n,
  input logic [N_SRC-1:0] stat0,
  input logic [N_SRC-1:0] stat1,
  input logic [N_SRC-1:0] mask0,
  input logic [N_SRC-1:0] mask1,
  input logic [1:0]       mode,
  input logic [EW-1:0]    edge_sel
);
  // R7
  irq0_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n[0] |-> $past(|(stat0 & ~mask0)));
  // R7
  irq1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat1 & ~mask1)) |=> !irq_n[1]);
  // R6
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask0 == '1) |=> irq_n[0]);
  // R8
  cor_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_STAT0 && mode[0]) |=> rdata[N_SRC-1:0] == $past(stat0));
  // R9
  w1c_read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == A_STAT1 && !mode[1]) |=> (stat1 & $past(stat1)) == $past(stat1));

  for (genvar i = 0; i < N_SRC; i++) begin : g_quiet
    // R4
    quiet_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel[2*i +: 2] == 2'b00 && !stat0[i]) |=> !stat0[i]);
  end
endmodule

bind dual_irq_ctrl dual_irq_ctrl_chk #(.N_SRC(N_SRC), .EW(EW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .rdata(rdata), .irq_n(irq_n), .stat0(stat_w[0]), .stat1(stat_w[1]),
  .mask0(mask_w[0]), .mask1(mask_w[1]), .mode(mode_q), .edge_sel(edge_q)
);

// File: tb/dual_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_in = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] irq_n;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dual_irq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    idle(3); rst_n = 1'b1; idle(1);

    // R1 reset state, R2 address map
    chk("R1 irq_n", {6'd0, irq_n}, 8'h03);
    rd(3'd0, d); chk("R1 stat0", d, 8'h00);
    rd(3'd1, d); chk("R1 mask0", d, 8'hFF);
    rd(3'd2, d); chk("R1 stat1", d, 8'h00);
    rd(3'd3, d); chk("R1 mask1", d, 8'hFF);
    rd(3'd4, d); chk("R1 edge0", d, 8'h00);
    rd(3'd5, d); chk("R1 edge1", d, 8'h00);
    rd(3'd6, d); chk("R1 mode", d, 8'h00);
    wr(3'd7, 8'h5A); rd(3'd7, d); chk("R2 spare", d, 8'h00);

    // R3 R4 R5 sweep: every source, every edge code, both directions
    wr(3'd1, 8'h00); wr(3'd3, 8'h00); wr(3'd6, 8'h03);
    for (int i = 0; i < 8; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic [7:0] ev_byte, bit_i;
        ev_byte = 8'(m << ((i % 4) * 2));
        bit_i = 8'(1 << i);
        wr(3'd4, (i < 4) ? ev_byte : 8'h00);
        wr(3'd5, (i < 4) ? 8'h00 : ev_byte);
        src_in[i] = 1'b1; idle(5);
        chk("R7 irq on rise", {7'd0, irq_n[0]}, (m & 2) ? 8'h00 : 8'h01);
        rd(3'd0, d); chk("R3 R5 rise line0", d, (m & 2) ? bit_i : 8'h00);
        rd(3'd2, d); chk("R3 R5 rise line1", d, (m & 2) ? bit_i : 8'h00);
        src_in[i] = 1'b0; idle(5);
        rd(3'd0, d); chk(m == 0 ? "R4 fall line0" : "R3 fall line0", d, (m & 1) ? bit_i : 8'h00);
        rd(3'd2, d); chk("R3 fall line1", d, (m & 1) ? bit_i : 8'h00);
        idle(1);
        chk("R7 irq released", {6'd0, irq_n}, 8'h03);
      end
    end

    // R7 timing: low exactly on the fourth edge after the input change
    wr(3'd4, 8'h03); wr(3'd5, 8'h00);
    src_in[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R7 not yet low", {7'd0, irq_n[0]}, 8'h01);
    @(negedge clk);
    chk("R7 low", {7'd0, irq_n[0]}, 8'h00);
    rd(3'd0, d); rd(3'd2, d);
    src_in[0] = 1'b0; idle(5); rd(3'd0, d); rd(3'd2, d);

    // R6 separate masks
    wr(3'd1, 8'hFF); wr(3'd3, 8'h00); wr(3'd4, 8'hC0);
    src_in[3] = 1'b1; idle(6);
    chk("R6 masked line0", {6'd0, irq_n}, 8'h01);
    rd(3'd0, d); chk("R6 status despite mask", d, 8'h08);
    rd(3'd2, d); idle(2);
    wr(3'd3, 8'hF7); src_in[3] = 1'b0; idle(6);
    chk("R6 bit unmasked line1", {6'd0, irq_n}, 8'h01);
    rd(3'd0, d); rd(3'd2, d);
    wr(3'd1, 8'h00); wr(3'd3, 8'h00);

    // R9 write-one-to-clear on line 0, R8 writes ignored in clear-on-read
    wr(3'd6, 8'h02);
    wr(3'd4, 8'h20); wr(3'd5, 8'h08);
    src_in[2] = 1'b1; src_in[5] = 1'b1; idle(5);
    rd(3'd0, d); chk("R9 read keeps", d, 8'h24);
    rd(3'd0, d); chk("R9 read keeps again", d, 8'h24);
    wr(3'd0, 8'h04); rd(3'd0, d); chk("R9 w1c one bit", d, 8'h20);
    wr(3'd0, 8'h00); rd(3'd0, d); chk("R9 write zero no effect", d, 8'h20);
    wr(3'd2, 8'hFF); rd(3'd2, d); chk("R8 write ignored", d, 8'h24);
    rd(3'd2, d); chk("R8 cleared by read", d, 8'h00);
    wr(3'd0, 8'h20); rd(3'd0, d); chk("R9 cleared", d, 8'h00);
    src_in[2] = 1'b0; src_in[5] = 1'b0; wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    idle(5);

    // R10 buffered second event
    wr(3'd6, 8'h03); wr(3'd4, 8'h0C);
    src_in[1] = 1'b1; idle(5); src_in[1] = 1'b0; idle(5);
    rd(3'd0, d); chk("R10 first", d, 8'h02);
    rd(3'd0, d); chk("R10 buffered", d, 8'h02);
    rd(3'd0, d); chk("R10 drained", d, 8'h00);
    rd(3'd2, d); rd(3'd2, d); rd(3'd2, d); chk("R10 line1 drained", d, 8'h00);

    // R11 clear coinciding with a new edge
    wr(3'd5, 8'h03);
    src_in[4] = 1'b1; idle(5);
    src_in[4] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd_en = 1'b1; addr = 3'd0;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    chk("R11 read during edge", rdata, 8'h10);
    rd(3'd0, d); chk("R11 edge won", d, 8'h10);
    rd(3'd0, d); chk("R11 then clear", d, 8'h00);
    rd(3'd2, d); chk("R10 line1 first", d, 8'h10);
    rd(3'd2, d); chk("R10 line1 buffered", d, 8'h10);
    rd(3'd2, d); chk("R10 line1 empty", d, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule